// File: doc/BRIEF.md
# Feedback-Controlled Memory Command Throttler

This block sits in the command path of a memory controller and holds average memory power near a programmable target. Time is cut into windows of a fixed number of cycles. In each window, commands pass freely for a budgeted number of cycles from the start of the window. After that they are held back until the window ends. Commands are stalled with backpressure and never dropped.

At the last cycle of every window, the block builds a power estimate from the reads and writes that completed a handshake during that window. It adds a static baseline to a read weight times the read count and a write weight times the write count. It subtracts this estimate from the setpoint and multiplies the error by a signed gain. The product is shifted right arithmetically, and the result is added to the current budget. The new budget is clamped and applied from the first cycle of the next window. The current budget is always visible on a status output.

The window sequencer has two states. In ACTIVE the path is open. In STALL it is closed. These are the transitions:
- Reset enters ACTIVE.
- ACTIVE→STALL ("budget spent") fires when the next cycle index reaches the budget and the window is not ending.
- ACTIVE→ACTIVE ("window wrap") fires at the last cycle of the window.
- STALL→ACTIVE ("window wrap") fires at the last cycle of the window.
- STALL→STALL ("hold") fires otherwise.

Top module: `mem_throttle_top`

## Requirements
- R1: Each window lasts WIN_LEN cycles. Cycle index c (0-based, restarting at every window) is active exactly when c < budget, where budget is the value on `budget_o` during that window.
- R2: In a stall cycle, `up_ready` and `dn_valid` are both 0 whatever the inputs are, so no command is accepted or forwarded.
- R3: In an active cycle, `dn_valid` equals `up_valid` and `up_ready` equals `dn_ready`. `dn_cmd` and `dn_is_write` copy `up_cmd` and `up_is_write`.
- R4: A transfer is counted only on a cycle with `up_valid` and `up_ready` both 1. It counts as a read when `up_is_write` is 0 and as a write when it is 1. Counts restart at 0 in each window.
- R5: The window estimate is `cfg_base + cfg_rd_wt*reads + cfg_wr_wt*writes`, with all terms unsigned.
- R6: The next budget before clamping is `budget + (((cfg_setpoint - estimate) * cfg_gain) >>> cfg_shift)`. The error is signed, `cfg_gain` is signed two's complement, and the shift is arithmetic.
- R7: The budget is clamped to the range from lo to WIN_LEN. Here lo is 1 when `cfg_min_budget` is 0, WIN_LEN when `cfg_min_budget` exceeds WIN_LEN, and `cfg_min_budget` otherwise.
- R8: While reset is asserted and after it is released, `budget_o` equals WIN_LEN, and the first window starts at cycle index 0 in ACTIVE.
- R9: `budget_o` changes only across the last cycle of a window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_valid | input | 1 | Requester command valid |
| up_ready | output | 1 | Ready toward requester |
| up_is_write | input | 1 | Command tag: 1 write, 0 read |
| up_cmd | input | CMD_W | Command payload |
| dn_valid | output | 1 | Command valid toward memory |
| dn_ready | input | 1 | Memory side ready |
| dn_is_write | output | 1 | Forwarded tag |
| dn_cmd | output | CMD_W | Forwarded payload |
| cfg_setpoint | input | PWR_W | Power target |
| cfg_base | input | PWR_W | Static baseline of the estimate |
| cfg_rd_wt | input | WT_W | Weight per read |
| cfg_wr_wt | input | WT_W | Weight per write |
| cfg_gain | input | GAIN_W | Signed loop gain |
| cfg_shift | input | SHIFT_W | Arithmetic right shift applied to the product |
| cfg_min_budget | input | CNT_W | Lower clamp of the budget |
| budget_o | output | CNT_W | Active budget of the current window |

## Verification
The budget only moves at a window boundary, and only after a whole window of handshakes has been counted. The hard cases are therefore the two clamp limits and a correction that changes sign from one window to the next, because each needs a chain of windows shaped by traffic. The bench keeps the window short and resets between several configurations. The configurations are a normal loop, a zero setpoint with large gain, a very high setpoint, an oversized minimum, and a negative gain. Valid and ready patterns change with cycle, window and configuration, so some cycles stall on the memory side, and the bench models the budget trajectory arithmetically over several windows of each configuration.

// File: rtl/thr_pkg.sv
package thr_pkg;
    typedef enum logic [0:0] {
        ST_ACTIVE = 1'b0,
        ST_STALL  = 1'b1
    } thr_state_e;
endpackage

// File: rtl/thr_window_fsm.sv
module thr_window_fsm
    import thr_pkg::*;
#(
    parameter int WIN_LEN = 10000,
    parameter int CNT_W   = $clog2(WIN_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] budget,
    output logic             active,
    output logic             win_last
);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WIN_LEN - 1);

    logic [CNT_W-1:0] wcnt;
    thr_state_e       state, state_nxt;

    assign win_last = (wcnt == LAST_IDX);

    // cycle index inside the window
    always_ff @(posedge clk) begin
        if (!rst_n)        wcnt <= '0;
        else if (win_last) wcnt <= '0;
        else               wcnt <= wcnt + CNT_W'(1);
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_ACTIVE;
        else        state <= state_nxt;
    end

    // transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_ACTIVE: begin
                if (win_last)                          state_nxt = ST_ACTIVE;
                else if ((wcnt + CNT_W'(1)) >= budget) state_nxt = ST_STALL;
            end
            ST_STALL: begin
                if (win_last) state_nxt = ST_ACTIVE;
            end
            default: state_nxt = ST_ACTIVE;
        endcase
    end

    // outputs
    always_comb begin
        active = 1'b0;
        unique case (state)
            ST_ACTIVE: active = 1'b1;
            ST_STALL:  active = 1'b0;
            default:   active = 1'b0;
        endcase
    end
endmodule

// File: rtl/thr_access_cnt.sv
module thr_access_cnt #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  logic             is_wr,
    input  logic             win_last,
    output logic [CNT_W-1:0] rd_tot,
    output logic [CNT_W-1:0] wr_tot
);
    logic [CNT_W-1:0] rd_cnt, wr_cnt;

    // totals include the transfer of the current cycle
    assign rd_tot = rd_cnt + CNT_W'(fire && !is_wr);
    assign wr_tot = wr_cnt + CNT_W'(fire &&  is_wr);

    always_ff @(posedge clk) begin
        if (!rst_n || win_last) begin
            rd_cnt <= '0;
            wr_cnt <= '0;
        end else begin
            rd_cnt <= rd_tot;
            wr_cnt <= wr_tot;
        end
    end
endmodule

// File: rtl/thr_budget_calc.sv
module thr_budget_calc #(
    parameter int WIN_LEN = 10000,
    parameter int CNT_W   = $clog2(WIN_LEN + 1),
    parameter int PWR_W   = 20,
    parameter int WT_W    = 8,
    parameter int GAIN_W  = 12,
    parameter int SHIFT_W = 6
) (
    input  logic                     [CNT_W-1:0]   budget,
    input  logic                     [CNT_W-1:0]   rd_tot,
    input  logic                     [CNT_W-1:0]   wr_tot,
    input  logic                     [PWR_W-1:0]   cfg_setpoint,
    input  logic                     [PWR_W-1:0]   cfg_base,
    input  logic                     [WT_W-1:0]    cfg_rd_wt,
    input  logic                     [WT_W-1:0]    cfg_wr_wt,
    input  logic signed              [GAIN_W-1:0]  cfg_gain,
    input  logic                     [SHIFT_W-1:0] cfg_shift,
    input  logic                     [CNT_W-1:0]   cfg_min_budget,
    output logic                     [CNT_W-1:0]   budget_nxt
);
    localparam int EST_W  = PWR_W + WT_W + CNT_W + 2;
    localparam int ERR_W  = EST_W + 1;
    localparam int PROD_W = ERR_W + GAIN_W;
    localparam int SUM_W  = PROD_W + 1;
    localparam logic [CNT_W-1:0] WIN_C = CNT_W'(WIN_LEN);

    logic        [EST_W-1:0]  est;
    logic signed [ERR_W-1:0]  err;
    logic signed [PROD_W-1:0] prod, delta;
    logic signed [SUM_W-1:0]  sum, lo_s, hi_s;
    logic        [CNT_W-1:0]  lo;

    assign est = EST_W'(cfg_base)
               + EST_W'(cfg_rd_wt) * EST_W'(rd_tot)
               + EST_W'(cfg_wr_wt) * EST_W'(wr_tot);

    assign err   = $signed(ERR_W'(cfg_setpoint)) - $signed(ERR_W'(est));
    assign prod  = PROD_W'(err) * PROD_W'(cfg_gain);
    assign delta = prod >>> cfg_shift;
    assign sum   = SUM_W'(delta) + $signed(SUM_W'(budget));

    assign lo   = (cfg_min_budget == '0)   ? CNT_W'(1) :
                  (cfg_min_budget > WIN_C) ? WIN_C : cfg_min_budget;
    assign lo_s = $signed(SUM_W'(lo));
    assign hi_s = $signed(SUM_W'(WIN_C));

    always_comb begin
        if (sum < lo_s)      budget_nxt = lo;
        else if (sum > hi_s) budget_nxt = WIN_C;
        else                 budget_nxt = CNT_W'(sum);
    end
endmodule

// File: rtl/mem_throttle_top.sv
module mem_throttle_top #(
    parameter int WIN_LEN = 10000,
    parameter int CNT_W   = $clog2(WIN_LEN + 1),
    parameter int CMD_W   = 32,
    parameter int PWR_W   = 20,
    parameter int WT_W    = 8,
    parameter int GAIN_W  = 12,
    parameter int SHIFT_W = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     up_valid,
    output logic                     up_ready,
    input  logic                     up_is_write,
    input  logic        [CMD_W-1:0]  up_cmd,
    output logic                     dn_valid,
    input  logic                     dn_ready,
    output logic                     dn_is_write,
    output logic        [CMD_W-1:0]  dn_cmd,
    input  logic        [PWR_W-1:0]  cfg_setpoint,
    input  logic        [PWR_W-1:0]  cfg_base,
    input  logic        [WT_W-1:0]   cfg_rd_wt,
    input  logic        [WT_W-1:0]   cfg_wr_wt,
    input  logic signed [GAIN_W-1:0] cfg_gain,
    input  logic        [SHIFT_W-1:0] cfg_shift,
    input  logic        [CNT_W-1:0]  cfg_min_budget,
    output logic        [CNT_W-1:0]  budget_o
);
    logic             active, win_last, fire;
    logic [CNT_W-1:0] rd_tot, wr_tot, budget_nxt, budget_q;

    assign up_ready    = active && dn_ready;
    assign dn_valid    = active && up_valid;
    assign dn_is_write = up_is_write;
    assign dn_cmd      = up_cmd;
    assign fire        = up_valid && up_ready;
    assign budget_o    = budget_q;

    thr_window_fsm #(.WIN_LEN(WIN_LEN), .CNT_W(CNT_W)) i_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .budget   (budget_q),
        .active   (active),
        .win_last (win_last)
    );

    thr_access_cnt #(.CNT_W(CNT_W)) i_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (fire),
        .is_wr    (up_is_write),
        .win_last (win_last),
        .rd_tot   (rd_tot),
        .wr_tot   (wr_tot)
    );

    thr_budget_calc #(
        .WIN_LEN(WIN_LEN), .CNT_W(CNT_W), .PWR_W(PWR_W),
        .WT_W(WT_W), .GAIN_W(GAIN_W), .SHIFT_W(SHIFT_W)
    ) i_calc (
        .budget         (budget_q),
        .rd_tot         (rd_tot),
        .wr_tot         (wr_tot),
        .cfg_setpoint   (cfg_setpoint),
        .cfg_base       (cfg_base),
        .cfg_rd_wt      (cfg_rd_wt),
        .cfg_wr_wt      (cfg_wr_wt),
        .cfg_gain       (cfg_gain),
        .cfg_shift      (cfg_shift),
        .cfg_min_budget (cfg_min_budget),
        .budget_nxt     (budget_nxt)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)        budget_q <= CNT_W'(WIN_LEN);
        else if (win_last) budget_q <= budget_nxt;
    end
endmodule

// File: rtl/thr_throttle_chk.sv
module thr_throttle_chk #(
    parameter int WIN_LEN = 10000,
    parameter int CNT_W   = $clog2(WIN_LEN + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             up_valid,
    input logic             up_ready,
    input logic             dn_valid,
    input logic             dn_ready,
    input logic [CNT_W-1:0] budget_o
);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WIN_LEN - 1);
    localparam logic [CNT_W-1:0] WIN_C    = CNT_W'(WIN_LEN);

    logic [CNT_W-1:0] wc;

    always_ff @(posedge clk) begin
        if (!rst_n)              wc <= '0;
        else if (wc == LAST_IDX) wc <= '0;
        else                     wc <= wc + CNT_W'(1);
    end

    // R2
    stall_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wc >= budget_o) |-> (!up_ready && !dn_valid));

    // R3
    active_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wc < budget_o) |-> (dn_valid == up_valid && up_ready == dn_ready));

    // R9
    budget_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wc != LAST_IDX) |=> $stable(budget_o));

    // R7
    budget_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (budget_o >= CNT_W'(1)) && (budget_o <= WIN_C));

    // R1
    first_cycle_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wc == '0) |-> (up_ready == dn_ready));
endmodule

bind mem_throttle_top thr_throttle_chk #(.WIN_LEN(WIN_LEN), .CNT_W(CNT_W)) i_thr_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_valid (up_valid),
    .up_ready (up_ready),
    .dn_valid (dn_valid),
    .dn_ready (dn_ready),
    .budget_o (budget_o)
);

// File: tb/test_mem_throttle_top.sv
module test_mem_throttle_top;
    localparam int CLK_PERIOD = 10;
    localparam int WIN   = 8;
    localparam int CW    = 4;
    localparam int CMDW  = 8;
    localparam int PW    = 12;
    localparam int WW    = 6;
    localparam int GW    = 10;
    localparam int SW    = 5;
    localparam int NCFG  = 6;
    localparam int NWIN  = 7;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            up_valid = 1'b0, up_is_write = 1'b0, dn_ready = 1'b0;
    logic [CMDW-1:0] up_cmd = '0;
    logic            up_ready, dn_valid, dn_is_write;
    logic [CMDW-1:0] dn_cmd;
    logic [PW-1:0]   cfg_setpoint = '0, cfg_base = '0;
    logic [WW-1:0]   cfg_rd_wt = '0, cfg_wr_wt = '0;
    logic signed [GW-1:0] cfg_gain = '0;
    logic [SW-1:0]   cfg_shift = '0;
    logic [CW-1:0]   cfg_min_budget = '0;
    logic [CW-1:0]   budget_o;

    int n_chk = 0, n_bad = 0;
    int sp, base, rw, ww, g, sh, mn;

    always #(CLK_PERIOD/2) clk = ~clk;

    mem_throttle_top #(
        .WIN_LEN(WIN), .CNT_W(CW), .CMD_W(CMDW), .PWR_W(PW),
        .WT_W(WW), .GAIN_W(GW), .SHIFT_W(SW)
    ) i_mem_throttle_top (
        .clk(clk), .rst_n(rst_n),
        .up_valid(up_valid), .up_ready(up_ready), .up_is_write(up_is_write), .up_cmd(up_cmd),
        .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_is_write(dn_is_write), .dn_cmd(dn_cmd),
        .cfg_setpoint(cfg_setpoint), .cfg_base(cfg_base), .cfg_rd_wt(cfg_rd_wt),
        .cfg_wr_wt(cfg_wr_wt), .cfg_gain(cfg_gain), .cfg_shift(cfg_shift),
        .cfg_min_budget(cfg_min_budget), .budget_o(budget_o)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int model_next(int b, int rd, int wr);
        longint est, err, prod, d, nb, lo;
        est  = longint'(base) + longint'(rw) * rd + longint'(ww) * wr;
        err  = longint'(sp) - est;
        prod = err * longint'(g);
        d    = prod >>> sh;
        nb   = longint'(b) + d;
        lo   = (mn == 0) ? 1 : ((mn > WIN) ? WIN : mn);
        if (nb < lo)  nb = lo;
        if (nb > WIN) nb = WIN;
        return int'(nb);
    endfunction

    task automatic set_cfg(input int k);
        case (k)
            0: begin sp = 100;  base = 20; rw = 5; ww = 9; g = 1;   sh = 0; mn = 2;  end
            1: begin sp = 60;   base = 10; rw = 7; ww = 3; g = 3;   sh = 1; mn = 1;  end
            2: begin sp = 0;    base = 5;  rw = 4; ww = 4; g = 50;  sh = 0; mn = 0;  end
            3: begin sp = 4000; base = 0;  rw = 1; ww = 1; g = 50;  sh = 0; mn = 3;  end
            4: begin sp = 0;    base = 50; rw = 9; ww = 9; g = 20;  sh = 0; mn = 15; end
            default: begin sp = 40; base = 8; rw = 3; ww = 6; g = -2; sh = 2; mn = 2; end
        endcase
        cfg_setpoint   = PW'(sp);
        cfg_base       = PW'(base);
        cfg_rd_wt      = WW'(rw);
        cfg_wr_wt      = WW'(ww);
        cfg_gain       = GW'(g);
        cfg_shift      = SW'(sh);
        cfg_min_budget = CW'(mn);
    endtask

    task automatic run_cfg(input int k);
        int b, rd, wr;
        bit v, t, r, act;
        set_cfg(k);
        @(negedge clk);
        rst_n = 1'b0;
        up_valid = 1'b1; dn_ready = 1'b1;
        @(negedge clk);
        @(negedge clk);
        #1;
        // R8: reset value and open path
        check(budget_o == CW'(WIN), "R8 reset budget", budget_o, WIN);
        check(up_ready == 1'b1, "R8 open during reset", up_ready, 1);
        b = WIN;
        for (int w = 0; w < NWIN; w++) begin
            rd = 0; wr = 0;
            for (int c = 0; c < WIN; c++) begin
                @(negedge clk);
                if (w == 0 && c == 0) rst_n = 1'b1;
                v = ((c + w + k) % 3) != 0;
                t = ((c + w) % 2) == 1;
                r = ((c + 2*k + w) % 5) != 4;
                up_valid = v; up_is_write = t; dn_ready = r;
                up_cmd = CMDW'(c*17 + w*3 + k);
                #1;
                act = (c < b);
                // R1 R2: stall after budget
                check(up_ready == (act && r), "R1/R2 up_ready", up_ready, act && r);
                check(dn_valid == (act && v), "R2/R3 dn_valid", dn_valid, act && v);
                if (act) begin
                    // R3 pass-through
                    check(dn_cmd == up_cmd && dn_is_write == t, "R3 payload", dn_cmd, up_cmd);
                end
                if (c == 0 || c == WIN/2) begin
                    // R9 R6 R7 R5 R4: budget for this window
                    check(budget_o == CW'(b), "R4/R5/R6/R7/R9 budget", budget_o, b);
                end
                if (act && v && r) begin
                    if (t) wr++; else rd++;
                end
            end
            b = model_next(b, rd, wr);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int k = 0; k < NCFG; k++) run_cfg(k);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule